// File: doc/BRIEF.md
# Edge-Sensing GPIO Port

This block controls a port of general-purpose pins through a small word-addressed register interface. Software drives the output level latch and the output-enable latch only through write-one-to-set, write-one-to-clear and write-one-to-toggle addresses. Bits written as 0 are left alone, so several agents can change single pins without a read-modify-write.

Every pin input passes through a two-flop synchronizer. The result is readable as a data-in word and also feeds a per-pin edge detector. A 2-bit code per pin chooses the edge that counts. Each counted edge latches a raw status bit whether or not the pin is masked. A mask word selects which raw bits reach the masked status word and the single interrupt line. Status bits go away only when software writes ones to a clear address.

The register addresses are word indices on a 4-bit address bus. Reads are combinational and qualified by the read enable. Writes take effect on the clock edge on which the write enable is high.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the following are all zero: the output latch (address 0), the output enable (address 4), both edge-select words (addresses 8 and 9), the mask (address 10) and the raw status (address 11). The outputs pin_out, pin_oe and irq are low.
- R2: The output latch is changed by writes to three addresses, and a 0 bit in the write data leaves the latch bit unchanged:
  - a 1 in bit n written to address 1 sets latch bit n;
  - a 1 written to address 2 clears it;
  - a 1 written to address 3 inverts it.
  The latch drives pin_out, and it reads back at address 0 from the clock edge after the write.
- R3: The output enable is changed by writes to two addresses, and a 0 bit in the write data leaves it unchanged:
  - a 1 in bit n written to address 5 sets enable bit n;
  - a 1 written to address 6 clears it.
  The enable drives pin_oe and reads back at address 4. Turning the enable off leaves the output latch value unchanged.
- R4: The data-in word at address 7 returns the pin_in levels after a two-flop synchronizer. A pin change set up before clock edge k is readable after edge k+1.
- R5: Each pin has a 2-bit edge code: 00 none, 01 rising, 10 falling, 11 both. Pin n below 16 uses bits [2n+1:2n] of address 8. Pin n of 16 or above uses bits [2(n-16)+1:2(n-16)] of address 9. An event is seen only for the edge kinds its code selects.
- R6: A selected edge on pin n sets bit n of the raw status (address 11), whatever the mask. For a pin change set up before clock edge k, the bit is set at edge k+2.
- R7: A raw status bit stays set until a 1 is written to that bit at the clear address 13. Bits written as 0 there are unchanged, and hardware never clears a bit on its own.
- R8: If a selected edge and a clear write hit the same raw bit in the same cycle, the bit ends up set.
- R9: The masked status (address 12) reads as raw status AND mask (address 10), and irq is high exactly when some masked bit is 1.
- R10: Reads of the write-only addresses 1, 2, 3, 5, 6 and 13 and of the unused addresses 14 and 15 return zero, and rdata is zero while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register word index |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, applied at the rising clock edge |
| rd_en | input | 1 | Read enable for the combinational read data |
| rdata | output | 32 | Read data |
| pin_in | input | 32 | Asynchronous pin input levels |
| pin_out | output | 32 | Output level latch |
| pin_oe | output | 32 | Output enable latch |
| irq | output | 1 | OR of all masked status bits |

## Verification
A latch bit set, cleared or inverted wrongly shows on pin_out or pin_oe one clock after the write, and it reads back wrong at once. A synchronizer with the wrong depth moves the data-in and raw-status timing by a cycle, and the cycle-exact samples catch that. A wrong edge decode, or a wrong pin-to-code bit position, sets the wrong raw bit or misses one; the sweep over every pin and code exposes this on the first status read after the edge. A raw bit that clears on its own, or a clear that beats a coincident edge, appears as a missing status bit and a low irq on the next read.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   localparam int REG_AW = 4;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   localparam logic [REG_AW-1:0] A_DOUT     = 4'd0;
   localparam logic [REG_AW-1:0] A_DOUT_SET = 4'd1;
   localparam logic [REG_AW-1:0] A_DOUT_CLR = 4'd2;
   localparam logic [REG_AW-1:0] A_DOUT_TGL = 4'd3;
   localparam logic [REG_AW-1:0] A_OE       = 4'd4;
   localparam logic [REG_AW-1:0] A_OE_SET   = 4'd5;
   localparam logic [REG_AW-1:0] A_OE_CLR   = 4'd6;
   localparam logic [REG_AW-1:0] A_DIN      = 4'd7;
   localparam logic [REG_AW-1:0] A_EDGE_LO  = 4'd8;
   localparam logic [REG_AW-1:0] A_EDGE_HI  = 4'd9;
   localparam logic [REG_AW-1:0] A_MASK     = 4'd10;
   localparam logic [REG_AW-1:0] A_RAW      = 4'd11;
   localparam logic [REG_AW-1:0] A_MASKED   = 4'd12;
   localparam logic [REG_AW-1:0] A_CLEAR    = 4'd13;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[0] <= '0;
            else        chain_q[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
   import gpio_edge_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WIDTH-1:0]   level,
   input  logic [2*WIDTH-1:0] sel,
   output logic [WIDTH-1:0]   event_out
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      edge_sel_e code;
      logic      rise;
      logic      fall;

      assign code = edge_sel_e'(sel[2*i +: 2]);
      assign rise = level[i] & ~prev_q[i];
      assign fall = ~level[i] & prev_q[i];

      always_comb begin
         unique case (code)
            EDGE_RISE: event_out[i] = rise;
            EDGE_FALL: event_out[i] = fall;
            EDGE_BOTH: event_out[i] = rise | fall;
            default:   event_out[i] = 1'b0;
         endcase
      end

      // R5: no event is reported for a pin whose code selects nothing
      assert_no_event_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
         event_out[i] |-> (sel[2*i +: 2] != 2'b00));
   end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_bits,
   input  logic [WIDTH-1:0] clr_bits,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] raw_q,
   output logic [WIDTH-1:0] masked,
   output logic             irq
);

   always_ff @(posedge clk) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= (raw_q & ~clr_bits) | set_bits;
   end

   assign masked = raw_q & mask;
   assign irq    = |masked;

   // R8: a coincident edge is never lost to a clear write
   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_bits != '0) |=> ((raw_q & $past(set_bits)) == $past(set_bits)));

   // R7: a raw bit only falls when software asked for it
   assert_no_auto_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(raw_q) & ~raw_q & ~$past(clr_bits)) == '0));

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
   import gpio_edge_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] pin_in,
   output logic [DATA_W-1:0] pin_out,
   output logic [DATA_W-1:0] pin_oe,
   output logic              irq
);

   localparam int NUM_PINS  = DATA_W;
   localparam int HALF_PINS = NUM_PINS / 2;

   if ((DATA_W % 2) != 0 || DATA_W < 2) begin : g_bad_width
      $error("gpio_edge_port: DATA_W must be even and at least 2");
   end
   if (2 * HALF_PINS * 2 != 2 * NUM_PINS) begin : g_bad_split
      $error("gpio_edge_port: edge codes must fill two words exactly");
   end

   logic [DATA_W-1:0]     dout_q, oe_q, mask_q;
   logic [DATA_W-1:0]     pol_lo_q, pol_hi_q;
   logic [DATA_W-1:0]     din_sync, pin_event, raw_st, masked_st, clr_bits;
   logic [2*NUM_PINS-1:0] pol_all;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout_q   <= '0;
         oe_q     <= '0;
         pol_lo_q <= '0;
         pol_hi_q <= '0;
         mask_q   <= '0;
      end else if (wr_en) begin
         unique case (addr)
            A_DOUT_SET: dout_q   <= dout_q | wdata;
            A_DOUT_CLR: dout_q   <= dout_q & ~wdata;
            A_DOUT_TGL: dout_q   <= dout_q ^ wdata;
            A_OE_SET:   oe_q     <= oe_q | wdata;
            A_OE_CLR:   oe_q     <= oe_q & ~wdata;
            A_EDGE_LO:  pol_lo_q <= wdata;
            A_EDGE_HI:  pol_hi_q <= wdata;
            A_MASK:     mask_q   <= wdata;
            default:    ;
         endcase
      end
   end

   assign clr_bits = (wr_en && addr == A_CLEAR) ? wdata : '0;
   assign pol_all  = {pol_hi_q, pol_lo_q};

   gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (din_sync)
   );

   gpio_edge_detect #(.WIDTH(NUM_PINS)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .level     (din_sync),
      .sel       (pol_all),
      .event_out (pin_event)
   );

   gpio_irq_status #(.WIDTH(NUM_PINS)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (pin_event),
      .clr_bits (clr_bits),
      .mask     (mask_q),
      .raw_q    (raw_st),
      .masked   (masked_st),
      .irq      (irq)
   );

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (addr)
            A_DOUT:    rdata = dout_q;
            A_OE:      rdata = oe_q;
            A_DIN:     rdata = din_sync;
            A_EDGE_LO: rdata = pol_lo_q;
            A_EDGE_HI: rdata = pol_hi_q;
            A_MASK:    rdata = mask_q;
            A_RAW:     rdata = raw_st;
            A_MASKED:  rdata = masked_st;
            default:   rdata = '0;
         endcase
      end
   end

   assign pin_out = dout_q;
   assign pin_oe  = oe_q;

   // R2: a toggle write inverts exactly the bits written as one
   assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_DOUT_TGL) |=> (pin_out == ($past(pin_out) ^ $past(wdata))));

   // R3: a clear-enable write turns off every bit written as one
   assert_oe_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_OE_CLR) |=> ((pin_oe & $past(wdata)) == '0));

   // R3: changing the enable never disturbs the output latch
   assert_oe_keeps_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (addr == A_OE_CLR || addr == A_OE_SET)) |=> $stable(pin_out));

endmodule

// File: tb/test_gpio_edge_port.sv
module test_gpio_edge_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [31:0] rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   gpio_edge_port i_gpio_edge_port (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      rd_en = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] v, model, lo, hi;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 pin_out", pin_out, 0);
      check("R1 pin_oe", pin_oe, 0);
      check("R1 irq", {31'd0, irq}, 0);
      rd(4'd0, v);  check("R1 dout", v, 0);
      rd(4'd4, v);  check("R1 oe", v, 0);
      rd(4'd8, v);  check("R1 edge_lo", v, 0);
      rd(4'd9, v);  check("R1 edge_hi", v, 0);
      rd(4'd10, v); check("R1 mask", v, 0);
      rd(4'd11, v); check("R1 raw", v, 0);

      // R2 set / clear / toggle aliases
      model = 0;
      for (int k = 0; k < 6; k++) begin
         logic [31:0] s, c, t;
         s = 32'h1234_5678 * (k + 1) ^ 32'hF0F0_0F0F;
         c = 32'h0101_0101 << k;
         t = 32'hFFFF_0000 >> (3 * k);
         wr(4'd1, s); model = model | s;
         rd(4'd0, v); check("R2 after set", v, model);
         wr(4'd2, c); model = model & ~c;
         rd(4'd0, v); check("R2 after clear", v, model);
         wr(4'd3, t); model = model ^ t;
         rd(4'd0, v); check("R2 after toggle", v, model);
         check("R2 pin_out", pin_out, model);
      end
      wr(4'd1, 32'h0); check("R2 zero set", pin_out, model);
      wr(4'd3, 32'h0); check("R2 zero toggle", pin_out, model);

      // R3 output enable and level retention
      wr(4'd5, 32'hFFFF_FFFF); check("R3 oe set", pin_oe, 32'hFFFF_FFFF);
      wr(4'd6, 32'h0000_FFFF); check("R3 oe clear", pin_oe, 32'hFFFF_0000);
      rd(4'd4, v); check("R3 oe read", v, 32'hFFFF_0000);
      check("R3 level kept", pin_out, model);
      wr(4'd6, 32'hFFFF_FFFF); check("R3 oe off", pin_oe, 0);
      wr(4'd5, 32'h0000_00FF); check("R3 oe reenable", pin_oe, 32'h0000_00FF);
      check("R3 level back", pin_out, model);

      // R10 write-only and unused reads
      foreach (v[i]) ;
      rd(4'd1, v);  check("R10 addr1", v, 0);
      rd(4'd2, v);  check("R10 addr2", v, 0);
      rd(4'd3, v);  check("R10 addr3", v, 0);
      rd(4'd5, v);  check("R10 addr5", v, 0);
      rd(4'd6, v);  check("R10 addr6", v, 0);
      rd(4'd13, v); check("R10 addr13", v, 0);
      rd(4'd14, v); check("R10 addr14", v, 0);
      rd(4'd15, v); check("R10 addr15", v, 0);
      @(negedge clk); addr = 4'd0; #1 check("R10 rd_en low", rdata, 0);

      // R4 data-in through the synchronizer (edge codes all zero here)
      for (int k = 0; k < 4; k++) begin
         logic [31:0] pat;
         pat = (k == 0) ? 32'hA5A5_5A5A : (k == 1) ? 32'hFFFF_FFFF :
               (k == 2) ? 32'h8000_0001 : 32'h0;
         @(negedge clk); pin_in = pat;
         @(posedge clk); @(posedge clk);
         @(negedge clk); addr = 4'd7; rd_en = 1'b1;
         #1 check("R4 din", rdata, pat);
         rd_en = 1'b0;
      end
      rd(4'd11, v); check("R5 code none gives no status", v, 0);

      // R5 / R6 sweep over every pin and every code
      for (int p = 0; p < 32; p++) begin
         for (int c = 0; c < 4; c++) begin
            lo = (p < 16) ? (32'(c) << (2 * p)) : 32'h0;
            hi = (p >= 16) ? (32'(c) << (2 * (p - 16))) : 32'h0;
            wr(4'd8, lo);
            wr(4'd9, hi);
            wr(4'd13, 32'hFFFF_FFFF);
            @(negedge clk); pin_in[p] = 1'b1;
            settle();
            rd(4'd11, v);
            check($sformatf("R6 rise pin%0d code%0d", p, c), v, (c & 1) ? (32'h1 << p) : 32'h0);
            check("R6 masked pin gives no irq", {31'd0, irq}, 0);
            wr(4'd13, 32'hFFFF_FFFF);
            @(negedge clk); pin_in[p] = 1'b0;
            settle();
            rd(4'd11, v);
            check($sformatf("R5 fall pin%0d code%0d", p, c), v, (c & 2) ? (32'h1 << p) : 32'h0);
            wr(4'd13, 32'hFFFF_FFFF);
         end
      end

      // R6 timing: set exactly at edge k+2
      wr(4'd8, 32'h0000_0003); // pin 0 both edges
      wr(4'd9, 32'h0000_0000);
      @(negedge clk); pin_in[0] = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk); addr = 4'd11; rd_en = 1'b1; #1 check("R6 not yet at k+1", rdata, 0);
      rd_en = 1'b0;
      @(posedge clk);
      @(negedge clk); addr = 4'd11; rd_en = 1'b1; #1 check("R6 set at k+2", rdata, 32'h1);
      rd_en = 1'b0;
      wr(4'd13, 32'hFFFF_FFFF);
      @(negedge clk); pin_in[0] = 1'b0;
      settle();
      wr(4'd13, 32'hFFFF_FFFF);

      // R7 clear semantics
      wr(4'd8, 32'h0000_0C00); // pin 5 both
      @(negedge clk); pin_in[5] = 1'b1;
      settle();
      wr(4'd13, 32'hFFFF_FFDF);
      rd(4'd11, v); check("R7 zero bit keeps status", v, 32'h20);
      repeat (20) @(posedge clk);
      rd(4'd11, v); check("R7 no auto clear", v, 32'h20);
      wr(4'd13, 32'h0000_0020);
      rd(4'd11, v); check("R7 write-one clears", v, 0);
      @(negedge clk); pin_in[5] = 1'b0;
      settle();
      wr(4'd13, 32'hFFFF_FFFF);

      // R9 mask, masked status, irq
      wr(4'd8, 32'h0000_00C0); // pin 3 both
      wr(4'd9, 32'h0000_00C0); // pin 19 both
      @(negedge clk); pin_in = 32'h0008_0008;
      settle();
      wr(4'd10, 32'h0008_0000);
      rd(4'd12, v); check("R9 masked one bit", v, 32'h0008_0000);
      check("R9 irq high", {31'd0, irq}, 1);
      wr(4'd10, 32'h0000_0080);
      rd(4'd12, v); check("R9 masked none", v, 0);
      check("R9 irq low", {31'd0, irq}, 0);
      wr(4'd10, 32'hFFFF_FFFF);
      rd(4'd12, v); check("R9 masked all", v, 32'h0008_0008);
      wr(4'd13, 32'h0008_0000);
      check("R9 irq after partial clear", {31'd0, irq}, 1);
      wr(4'd13, 32'h0000_0008);
      check("R9 irq after full clear", {31'd0, irq}, 0);
      wr(4'd10, 32'h0);
      @(negedge clk); pin_in = 32'h0;
      settle();
      wr(4'd13, 32'hFFFF_FFFF);

      // R8 edge and clear in the same cycle
      wr(4'd8, 32'h000C_0000); // pin 9 both
      wr(4'd9, 32'h0);
      @(negedge clk); pin_in[9] = 1'b1;
      settle();
      rd(4'd11, v); check("R8 precondition", v, 32'h200);
      @(negedge clk); pin_in[9] = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk); addr = 4'd13; wdata = 32'h200; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk); wr_en = 1'b0;
      rd(4'd11, v); check("R8 set wins", v, 32'h200);
      wr(4'd13, 32'h200);
      rd(4'd11, v); check("R8 later clear", v, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule